// File: doc/BRIEF.md
# Tag Compare SRAM Core

A synchronous word-wide memory with a built-in equality comparator, meant to hold cache tags. Each word has two 9-bit lanes. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Within each lane the top bit is that lane's parity bit.

All commands are sampled on the rising clock edge. A write is requested either by the global write strobe or by the byte write enable together with per-lane select strobes. The data input register is the only source of write data. It loads only on edges where the data-enable strobe is low.

Any cycle without a write is a read. The stored word at the sampled address is compared against the data input register, bit for bit. A compare cycle is a read with the data output enable held off, so that the compare pattern can be loaded into the input register on the same edge.

A static mode input selects pipelined operation, where data and match are registered, or flow-through operation, where they are not. Both output enables act asynchronously. Each enable produces a drive flag for the pad ring.

Top module: `tagram_cmp_core`

## Requirements
- R1: With gw_n low at an edge, both lanes of the addressed word are written, whatever bwe_n and bw_n are.
- R2: With gw_n high and bwe_n low, lane i is written only when bw_n[i] is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9, and each lane's parity bit is included.
- R3: With gw_n and bwe_n both high, nothing is written and the cycle is a read; bw_n has no effect.
- R4: The data input register loads din only on edges where de_n is low. A write stores the register's content. A write commits on the following edge, so a read of the same address in the next cycle returns the new word.
- R5: In flow-through mode (pipe_mode=0), dq_o shows the word at the address sampled at an edge, just after that edge. In pipelined mode (pipe_mode=1), it appears after the following edge.
- R6: The match flag for a read is 1 only when all 18 bits of the stored word equal the data input register. The match flag for a write cycle is 0.
- R7: The match flag follows the same one-edge or two-edge timing as dq_o, chosen by pipe_mode.
- R8: match_drive equals the inverse of moe_n, and dq_drive is high only while oe_n is low and a read result is presented. Both enables take effect without waiting for a clock edge.
- R9: While rst_n is low, match_o and dq_drive are 0, and in pipelined mode dq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipe_mode | input | 1 | 1 = registered outputs, 0 = flow-through |
| addr | input | AW (8) | Word address |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES (2) | Per-lane byte write selects, active low |
| de_n | input | 1 | Data input register load enable, active low |
| din | input | WORD_W (18) | Write or compare data |
| oe_n | input | 1 | Asynchronous data output enable, active low |
| moe_n | input | 1 | Asynchronous match output enable, active low |
| dq_o | output | WORD_W (18) | Read data |
| dq_drive | output | 1 | High when the data pads should drive |
| match_o | output | 1 | Compare result |
| match_drive | output | 1 | High when the match pad should drive |

## Verification
In flow-through mode, read data, match and the data drive flag are due just after the edge that samples the command. The bench therefore drives each command on the falling edge and samples 2 ns after the next rising edge. In pipelined mode the same results are due one edge later. The bench checks that they have not yet appeared after the first edge, and then checks them after the second. The two enables have no clock latency, so they are toggled mid-cycle and checked 1 ns later. A write lands on the edge after its command, so every read-back is issued in the very next cycle to exercise that latency.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;
    localparam int DEF_DEPTH  = 256;
endpackage

// File: rtl/tagram_wr_decode.sv
module tagram_wr_decode #(
    parameter int LANES = tagram_pkg::DEF_LANES
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    // Global write wins; otherwise a lane needs both the enable and its select.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = !gw_n || (!bwe_n && !bw_n[i]);
    end
endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
    parameter int DEPTH  = tagram_pkg::DEF_DEPTH,
    parameter int LANE_W = tagram_pkg::DEF_LANE_W,
    parameter int LANES  = tagram_pkg::DEF_LANES,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic [LANES-1:0]  lane_we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[i]) begin
                mem[waddr] <= wdata[i*LANE_W +: LANE_W];
            end
        end

        assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/tagram_match.sv
module tagram_match #(
    parameter int LANE_W = tagram_pkg::DEF_LANE_W,
    parameter int LANES  = tagram_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] stored,
    input  logic [WORD_W-1:0] probe,
    output logic              hit
);
    logic [LANES-1:0] lane_eq;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_eq[i] = (stored[i*LANE_W +: LANE_W] == probe[i*LANE_W +: LANE_W]);
    end

    assign hit = valid && (&lane_eq);
endmodule

// File: rtl/tagram_cmp_core.sv
module tagram_cmp_core #(
    parameter int DEPTH  = tagram_pkg::DEF_DEPTH,
    parameter int LANE_W = tagram_pkg::DEF_LANE_W,
    parameter int LANES  = tagram_pkg::DEF_LANES,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic [AW-1:0]     addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              de_n,
    input  logic [WORD_W-1:0] din,
    input  logic              oe_n,
    input  logic              moe_n,
    output logic [WORD_W-1:0] dq_o,
    output logic              dq_drive,
    output logic              match_o,
    output logic              match_drive
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [LANES-1:0]  wen;
        logic              rd;
        logic [WORD_W-1:0] din;
        logic              rd2;
        logic [WORD_W-1:0] dq;
        logic              match;
    } state_t;

    state_t s_d, s_q;

    logic [LANES-1:0]  cmd_we;
    logic [WORD_W-1:0] rdata;
    logic              match_now;
    logic [WORD_W-1:0] din_q;

    tagram_wr_decode #(.LANES(LANES)) u_dec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (cmd_we)
    );

    tagram_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .LANES(LANES)) u_arr (
        .clk     (clk),
        .lane_we (s_q.wen),
        .waddr   (s_q.addr),
        .wdata   (s_q.din),
        .raddr   (s_q.addr),
        .rdata   (rdata)
    );

    tagram_match #(.LANE_W(LANE_W), .LANES(LANES)) u_cmp (
        .valid  (s_q.rd),
        .stored (rdata),
        .probe  (s_q.din),
        .hit    (match_now)
    );

    always_comb begin
        s_d       = s_q;
        s_d.addr  = addr;
        s_d.wen   = cmd_we;
        s_d.rd    = ~|cmd_we;
        s_d.din   = de_n ? s_q.din : din;
        s_d.rd2   = s_q.rd;
        s_d.dq    = rdata;
        s_d.match = match_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign din_q       = s_q.din;
    assign dq_o        = pipe_mode ? s_q.dq : rdata;
    assign dq_drive    = !oe_n && (pipe_mode ? s_q.rd2 : s_q.rd);
    assign match_o     = pipe_mode ? s_q.match : match_now;
    assign match_drive = !moe_n;
endmodule

// File: rtl/tagram_cmp_chk.sv
module tagram_cmp_chk #(
    parameter int LANES  = 2,
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pipe_mode,
    input logic              gw_n,
    input logic              bwe_n,
    input logic [LANES-1:0]  bw_n,
    input logic              de_n,
    input logic              moe_n,
    input logic              match_o,
    input logic              match_drive,
    input logic              dq_drive,
    input logic              match_now,
    input logic [WORD_W-1:0] din_q
);
    logic wr_cmd;
    assign wr_cmd = !gw_n || (!bwe_n && (bw_n != '1));

    AST_WR_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !pipe_mode) |=> (pipe_mode || !match_o)); // R6

    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !pipe_mode) |=> (pipe_mode || !dq_drive)); // R8

    AST_DE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        de_n |=> $stable(din_q)); // R4

    AST_PIPE_MATCH_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode)) |-> (match_o == $past(match_now))); // R7

    AST_MOE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        moe_n |-> !match_drive); // R8
endmodule

bind tagram_cmp_core tagram_cmp_chk #(.LANES(LANES), .WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pipe_mode   (pipe_mode),
    .gw_n        (gw_n),
    .bwe_n       (bwe_n),
    .bw_n        (bw_n),
    .de_n        (de_n),
    .moe_n       (moe_n),
    .match_o     (match_o),
    .match_drive (match_drive),
    .dq_drive    (dq_drive),
    .match_now   (match_now),
    .din_q       (din_q)
);

// File: tb/tagram_cmp_core_tb.sv
module tagram_cmp_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_mode = 1'b1;
    logic [7:0]  addr = '0;
    logic        gw_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic        de_n = 1'b1;
    logic [17:0] din = '0;
    logic        oe_n = 1'b0;
    logic        moe_n = 1'b0;
    logic [17:0] dq_o;
    logic        dq_drive;
    logic        match_o;
    logic        match_drive;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tagram_cmp_core dut_i (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .addr(addr),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .de_n(de_n), .din(din),
        .oe_n(oe_n), .moe_n(moe_n), .dq_o(dq_o), .dq_drive(dq_drive),
        .match_o(match_o), .match_drive(match_drive)
    );

    typedef struct packed {
        logic        gw_n;
        logic        bwe_n;
        logic [1:0]  bw_n;
        logic        de_n;
        logic [7:0]  a;
        logic [17:0] d;
        logic        is_rd;
        logic [17:0] exp_dq;
        logic        exp_m;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b1, 2'b11, 1'b0, 8'd1, {9'h1A3, 9'h05C}, 1'b0, 18'h0, 1'b0},             // R1 write
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'd1, 18'h3FFFF, 1'b1, {9'h1A3, 9'h05C}, 1'b1},         // R4 next-cycle read
        '{1'b1, 1'b0, 2'b10, 1'b0, 8'd1, {9'h0FF, 9'h111}, 1'b0, 18'h0, 1'b0},             // R2 lane0
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'd1, 18'h0, 1'b1, {9'h1A3, 9'h111}, 1'b0},             // R2 R6
        '{1'b1, 1'b0, 2'b01, 1'b0, 8'd1, {9'h022, 9'h1EE}, 1'b0, 18'h0, 1'b0},             // R2 lane1
        '{1'b1, 1'b1, 2'b11, 1'b0, 8'd1, {9'h022, 9'h111}, 1'b1, {9'h022, 9'h111}, 1'b1},  // R6 hit
        '{1'b1, 1'b1, 2'b11, 1'b0, 8'd1, {9'h122, 9'h111}, 1'b1, {9'h022, 9'h111}, 1'b0},  // R6 parity miss
        '{1'b1, 1'b1, 2'b00, 1'b0, 8'd1, 18'h0, 1'b1, {9'h022, 9'h111}, 1'b0},             // R3 no write
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'd1, 18'h0, 1'b1, {9'h022, 9'h111}, 1'b0},             // R3 unchanged
        '{1'b0, 1'b0, 2'b11, 1'b0, 8'd2, {9'h155, 9'h0AA}, 1'b0, 18'h0, 1'b0},             // R1 overrides
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'd2, 18'h0, 1'b1, {9'h155, 9'h0AA}, 1'b1},             // R1 both lanes
        '{1'b0, 1'b1, 2'b11, 1'b1, 8'd3, {9'h1FF, 9'h1FF}, 1'b0, 18'h0, 1'b0},             // R4 stale reg
        '{1'b1, 1'b1, 2'b11, 1'b1, 8'd3, 18'h0, 1'b1, {9'h155, 9'h0AA}, 1'b1}              // R4 stored reg
    };

    task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic g, input logic b, input logic [1:0] s, input logic de,
                         input logic [7:0] a, input logic [17:0] d);
        @(negedge clk);
        gw_n = g; bwe_n = b; bw_n = s; de_n = de; addr = a; din = d;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state in pipelined mode
        #20;
        chk(dq_o == 18'h0, "R9 dq_o in reset", dq_o, 18'h0);
        chk(match_o == 1'b0, "R9 match_o in reset", {17'h0, match_o}, 18'h0);
        chk(dq_drive == 1'b0, "R9 dq_drive in reset", {17'h0, dq_drive}, 18'h0);
        chk(match_drive == 1'b1, "R8 match_drive in reset", {17'h0, match_drive}, 18'h1);
        @(negedge clk);
        rst_n = 1'b1;
        pipe_mode = 1'b0;

        // R5 R6 R1 R2 R3 R4: flow-through vector walk
        for (int i = 0; i < NV; i++) begin
            drive(VT[i].gw_n, VT[i].bwe_n, VT[i].bw_n, VT[i].de_n, VT[i].a, VT[i].d);
            chk(match_o == VT[i].exp_m, $sformatf("R6 match row %0d", i),
                {17'h0, match_o}, {17'h0, VT[i].exp_m});
            chk(dq_drive == VT[i].is_rd, $sformatf("R8 dq_drive row %0d", i),
                {17'h0, dq_drive}, {17'h0, VT[i].is_rd});
            if (VT[i].is_rd) begin
                chk(dq_o == VT[i].exp_dq, $sformatf("R5 dq_o row %0d", i), dq_o, VT[i].exp_dq);
            end
        end

        // R8: asynchronous enables, mid-cycle
        #1 oe_n = 1'b1;
        #1 chk(dq_drive == 1'b0, "R8 oe_n async off", {17'h0, dq_drive}, 18'h0);
        moe_n = 1'b1;
        #1 chk(match_drive == 1'b0, "R8 moe_n async off", {17'h0, match_drive}, 18'h0);
        oe_n = 1'b0;
        moe_n = 1'b0;
        #1 chk(dq_drive == 1'b1, "R8 oe_n async on", {17'h0, dq_drive}, 18'h1);
        chk(match_drive == 1'b1, "R8 moe_n async on", {17'h0, match_drive}, 18'h1);

        // R5 R7: pipelined timing
        @(negedge clk);
        pipe_mode = 1'b1;
        drive(1'b0, 1'b1, 2'b11, 1'b0, 8'd4, {9'h0F0, 9'h00F});
        drive(1'b1, 1'b1, 2'b11, 1'b0, 8'd4, {9'h0F0, 9'h00F});
        chk(match_o == 1'b0, "R7 pipe match not yet", {17'h0, match_o}, 18'h0);
        chk(dq_drive == 1'b0, "R5 pipe drive not yet", {17'h0, dq_drive}, 18'h0);
        drive(1'b1, 1'b1, 2'b11, 1'b1, 8'd0, 18'h0);
        chk(match_o == 1'b1, "R7 pipe match due", {17'h0, match_o}, 18'h1);
        chk(dq_o == {9'h0F0, 9'h00F}, "R5 pipe dq due", dq_o, {9'h0F0, 9'h00F});
        chk(dq_drive == 1'b1, "R5 pipe drive due", {17'h0, dq_drive}, 18'h1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule